// File: doc/BRIEF.md
# Debounced Dual-Edge Input Event Detector

This block watches seven board-level inputs: the power button, three keys, the AC-present indication, the embedded-controller reset line and the flash write-protect line. For each one it looks for falling and rising transitions. A transition counts only when the new level holds for a programmable stability window. The clock is the 200 kHz always-on clock, so one debounce step is 5 us.

Every qualified transition whose enable bit is set raises a sticky status bit. Software clears a status bit by writing 1 to it, and that write reaches the block as a one-cycle clear strobe. A single interrupt line is high while any status bit is set.

The register layer holds the configuration. It resets the debounce field to 2000 and the enable bits to 0. The inputs reach the block already synchronised to its clock.

Top module: `pin_edge_irq`

## Requirements
- R1: A change on an input is accepted only when the new level is sampled on D+2 consecutive clock edges, where D is `debounce_i`. The status bit is visible after the last of those edges.
- R2: Input index order is power button 0, key0 1, key1 2, key2 3, AC present 4, EC reset 5, flash write protect 6. Bit i (0..6) of the enable, clear and status vectors is the falling edge of input i. Bit 7+i is the rising edge of input i.
- R3: An accepted edge sets its status bit only when the matching `edge_en_i` bit is 1. A disabled edge leaves every status bit unchanged.
- R4: A status bit stays set until its `clr_i` bit is 1 at a clock edge. Clearing one bit leaves the others as they are.
- R5: If an input returns to its accepted level before acceptance, no event is produced and the old level is kept.
- R6: With D = 0, a changed level is accepted on the second clock edge that samples it.
- R7: On the first clock edge after reset, each input's current level becomes its accepted level. No event is produced on that edge, whatever the pin levels are.
- R8: If a clear and a new event hit the same status bit on the same edge, the bit ends up set.
- R9: `irq_o` is 1 exactly when at least one status bit is 1.
- R10: While reset is held and right after it, `status_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock; one cycle is one debounce step |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 7 | Synchronised input levels, index order as in R2 |
| edge_en_i | input | 14 | Per-edge enable: falling edges in bits 6:0, rising edges in bits 13:7 |
| debounce_i | input | 16 | Stability window D in clock cycles |
| clr_i | input | 14 | Write-1-to-clear strobe, same layout as status |
| status_o | output | 14 | Sticky event bits |
| irq_o | output | 1 | OR of all status bits |

## Verification
The hardest cases to reach from the ports involve exact timing. One is a glitch that lasts exactly one sample less than the window. The other is a software clear that lands on the very edge where a new event for the same bit is accepted.

The bench reaches both by driving pins on the falling clock edge and counting edges from the change. It places the clear strobe one cycle after a D = 0 transition begins. A long random phase then toggles pins, enables and clears under a short window, and a behavioural model checks the result on every clock.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;
  localparam int DEF_PINS  = 7;
  localparam int DEF_CNT_W = 16;

  typedef enum logic {
    DB_HOLD  = 1'b0,
    DB_TRIAL = 1'b1
  } db_state_e;
endpackage

// File: rtl/pin_debounce.sv
module pin_debounce
  import pin_edge_pkg::*;
#(
  parameter int CntW = DEF_CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            pin_i,
  input  logic [CntW-1:0] limit_i,
  output logic            fall_o,
  output logic            rise_o
);
  // window is complete once the trial counter has reached the limit
  function automatic logic window_done(input logic [CntW-1:0] cnt,
                                       input logic [CntW-1:0] lim);
    return cnt >= lim;
  endfunction

  function automatic logic [CntW-1:0] sat_inc(input logic [CntW-1:0] cnt);
    return (cnt == {CntW{1'b1}}) ? cnt : cnt + 1'b1;
  endfunction

  db_state_e       state_q;
  logic            level_q;
  logic [CntW-1:0] cnt_q;
  logic            differs;
  logic            accept;

  assign differs = (pin_i != level_q);
  assign accept  = (state_q == DB_TRIAL) && differs && window_done(cnt_q, limit_i);
  assign fall_o  = accept && !pin_i;
  assign rise_o  = accept && pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DB_HOLD;
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      state_q <= DB_HOLD;
      level_q <= pin_i;
      cnt_q   <= '0;
    end else if (!differs || accept) begin
      state_q <= DB_HOLD;
      cnt_q   <= '0;
      if (accept) level_q <= pin_i;
    end else if (state_q == DB_HOLD) begin
      state_q <= DB_TRIAL;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= sat_inc(cnt_q);
    end
  end
endmodule

// File: rtl/edge_status.sv
module edge_status #(
  parameter int NumBits = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NumBits-1:0] set_i,
  input  logic [NumBits-1:0] clr_i,
  output logic [NumBits-1:0] status_o
);
  // a fresh event outranks a clear on the same edge
  function automatic logic [NumBits-1:0] next_status(input logic [NumBits-1:0] cur,
                                                     input logic [NumBits-1:0] set,
                                                     input logic [NumBits-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= next_status(status_o, set_i, clr_i);
  end
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_pkg::*;
#(
  parameter int NumPins = DEF_PINS,
  parameter int CntW    = DEF_CNT_W,
  localparam int NumBits = 2 * NumPins
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NumPins-1:0] pins_i,
  input  logic [NumBits-1:0] edge_en_i,
  input  logic [CntW-1:0]    debounce_i,
  input  logic [NumBits-1:0] clr_i,
  output logic [NumBits-1:0] status_o,
  output logic               irq_o
);
  logic               primed_q;
  logic [NumPins-1:0] fall_evt;
  logic [NumPins-1:0] rise_evt;
  logic [NumBits-1:0] set_vec;

  // first edge after reset only captures the pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  for (genvar g = 0; g < NumPins; g++) begin : g_pin
    pin_debounce #(.CntW(CntW)) db_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (!primed_q),
      .pin_i   (pins_i[g]),
      .limit_i (debounce_i),
      .fall_o  (fall_evt[g]),
      .rise_o  (rise_evt[g])
    );
  end

  assign set_vec = {rise_evt, fall_evt} & edge_en_i;

  edge_status #(.NumBits(NumBits)) st_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_i),
    .status_o (status_o)
  );

  assign irq_o = |status_o;
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
  parameter int NumPins = 7,
  localparam int NumBits = 2 * NumPins
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NumPins-1:0] pins_i,
  input logic [NumBits-1:0] edge_en_i,
  input logic [NumBits-1:0] clr_i,
  input logic [NumBits-1:0] status_o,
  input logic               primed,
  input logic [NumPins-1:0] fall_evt,
  input logic [NumPins-1:0] rise_evt
);
  AST_EVENT_NEEDS_HELD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fall_evt & $past(pins_i)) == '0) && ((rise_evt & ~$past(pins_i)) == '0)); // R1
  AST_EVENT_MATCHES_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fall_evt & pins_i) == '0) && ((rise_evt & ~pins_i) == '0)); // R2
  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(edge_en_i)) == '0)); // R3
  AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0)); // R4
  AST_NO_EVENT_WHILE_LOADING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |-> (fall_evt == '0 && rise_evt == '0)); // R7
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past({rise_evt, fall_evt} & edge_en_i) & ~status_o) == '0)); // R8
endmodule

bind pin_edge_irq pin_edge_irq_chk #(.NumPins(NumPins)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pins_i    (pins_i),
  .edge_en_i (edge_en_i),
  .clr_i     (clr_i),
  .status_o  (status_o),
  .primed    (primed_q),
  .fall_evt  (fall_evt),
  .rise_evt  (rise_evt)
);

// File: tb/pin_edge_irq_tb_top.sv
module pin_edge_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  pins = 7'h7F;
  logic [13:0] en = '0;
  logic [15:0] deb = 16'd3;
  logic [13:0] clr = '0;
  logic [13:0] status;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_edge_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .edge_en_i(en),
    .debounce_i(deb), .clr_i(clr), .status_o(status), .irq_o(irq)
  );

  // behavioural reference: run length of samples away from the accepted level
  bit          m_primed;
  bit [6:0]    m_level;
  int          m_run[7];
  logic [13:0] m_status;

  always @(posedge clk) begin
    logic [13:0] ev;
    ev = '0;
    if (!rst_n) begin
      m_primed = 0;
      m_status = '0;
      for (int i = 0; i < 7; i++) m_run[i] = 0;
    end else if (!m_primed) begin
      m_level  = pins;
      m_primed = 1;
      m_status = m_status & ~clr;
    end else begin
      for (int i = 0; i < 7; i++) begin
        if (pins[i] !== m_level[i]) begin
          m_run[i]++;
          if (m_run[i] >= int'(deb) + 2) begin
            if (pins[i]) ev[i + 7] = 1'b1;
            else         ev[i] = 1'b1;
            m_level[i] = pins[i];
            m_run[i] = 0;
          end
        end else begin
          m_run[i] = 0;
        end
      end
      m_status = (m_status & ~clr) | (ev & en);
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_primed) begin
      checks++;
      if (status !== m_status || irq !== (m_status != 0)) begin
        fails++;
        $display("FAIL R1/R3 per-cycle model: status=%h irq=%b expected status=%h irq=%b",
                 status, irq, m_status, m_status != 0);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [13:0] exp);
    checks++;
    if (status !== exp || irq !== (exp != 0)) begin
      fails++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, status, irq, exp, exp != 0);
    end
  endtask

  initial begin
    step(3);
    chk("R10 status during reset", 14'h0000);
    rst_n = 1'b1;
    en = 14'h3FFF;
    step(1);
    chk("R10 status after reset", 14'h0000);
    step(5);
    chk("R7 no event from initial high pins", 14'h0000);

    // R5: glitch one sample short of the window (D=3 needs 5 samples)
    pins[0] = 1'b0; step(4);
    pins[0] = 1'b1; step(6);
    chk("R5 short glitch rejected", 14'h0000);

    // R1 R2: falling edge of power button
    pins[0] = 1'b0; step(4);
    chk("R1 not yet accepted", 14'h0000);
    step(1);
    chk("R1 R2 fall of input 0 in bit 0", 14'h0001);
    pins[0] = 1'b1; step(5);
    chk("R2 rise of input 0 in bit 7", 14'h0081);

    // R4 R9: clear one bit, then the other
    clr = 14'h0001; step(1); clr = '0;
    chk("R4 partial clear", 14'h0080);
    clr = 14'h0080; step(1); clr = '0;
    chk("R9 irq drops with last bit", 14'h0000);

    // R3: disabled falling edge of EC reset
    en = 14'h3FFF & ~14'h0020;
    pins[5] = 1'b0; step(8);
    chk("R3 disabled edge ignored", 14'h0000);
    en = 14'h3FFF;

    // R6: zero window
    deb = 16'd0;
    pins[3] = 1'b0; step(1);
    chk("R6 first sample not enough", 14'h0000);
    step(1);
    chk("R6 accepted on second edge", 14'h0008);
    clr = 14'h0008; step(1); clr = '0;

    // R8: clear on the acceptance edge of the same bit
    pins[4] = 1'b0; step(2);
    chk("R2 fall of input 4 in bit 4", 14'h0010);
    pins[4] = 1'b1; step(2);
    chk("R2 rise of input 4 in bit 11", 14'h0810);
    pins[4] = 1'b0; step(1);
    clr = 14'h0010; step(1); clr = '0;
    chk("R8 event wins over clear", 14'h0810);
    clr = 14'h3FFF; step(1); clr = '0;
    chk("R4 clear all", 14'h0000);

    // random phase, checked by the per-cycle model
    deb = 16'd2;
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) en = 14'($urandom);
      if ($urandom % 4 == 0) pins[$urandom % 7] ^= 1'b1;
      clr = ($urandom % 16 == 0) ? 14'($urandom) : 14'h0;
      step(1);
    end
    clr = '0;
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule